// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Logic

This block builds the eight-bit, read-only line status byte of a UART that has receive and transmit FIFOs. The surrounding FIFO and serial engines report events to it: a character pushed into the receive FIFO with its error tag, a character popped from the head, a new character reaching the head, whether the FIFO is full or non-empty, and whether the transmit holding and shift registers are empty. Software reads the byte through a read strobe, and that strobe drives the clear-on-read behaviour.

The parity, framing and break flags describe the character at the head of the receive FIFO. They are captured when that character reaches the head and are cleared by a status read. A summary flag reports that errored characters are still in the FIFO. The block keeps its own count of tagged characters so that this flag clears only once none of them remain. The transmit flags show whether the holding register, and the holding and shift registers together, are empty.

Top module: `uart_lsr`

## Requirements
- R1: Status bit 0 (data ready) equals the `rx_nonempty` input in the same cycle.
- R2: Status bit 1 (overrun) sets on the edge after a push while `rx_full` is high. It clears after a status read. A set in the same cycle as a read wins.
- R3: On the edge after `rx_head_load`, status bits 2, 3 and 4 take the values of `rx_head_tag` bits 0 (parity), 1 (framing) and 2 (break).
- R4: A status read without a coinciding `rx_head_load` clears status bits 2 to 4 on the next edge. When the two coincide, the new head tag is loaded.
- R5: Status bit 5 (holding empty) resets to 1. It clears on the edge after `thr_wr`. Otherwise it sets on the edge after `thr_empty` is seen high. A write wins over an empty report.
- R6: Status bit 6 (transmitter empty) is 1 exactly when status bit 5 is 1 and `tsr_empty` is high.
- R7: The internal count of errored characters rises on an accepted push (not full) with a non-zero tag and falls on a pop with a non-zero `rx_pop_tag`. It never exceeds the FIFO depth.
- R8: Status bit 7 (FIFO error) sets on the edge after `rx_head_load` with a non-zero `rx_head_tag`. A status read clears it only if the errored count after that cycle's update is zero.
- R9: While `fifo_en` is low, status bit 7 is 0 from the next edge on.
- R10: After reset, with `rx_nonempty` low and `tsr_empty` high, the status byte reads 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_push_tag | input | 3 | Error tag of the pushed character {break, framing, parity} |
| rx_full | input | 1 | Receive FIFO full |
| rx_pop | input | 1 | Head character removed |
| rx_pop_tag | input | 3 | Error tag of the removed character |
| rx_head_load | input | 1 | A new character reaches the head this cycle |
| rx_head_tag | input | 3 | Error tag of the character reaching the head |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| thr_wr | input | 1 | Write to the transmit holding register |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | Status byte read strobe |
| lsr | output | 8 | Status byte {fifo_err, temt, thre, brk, frm, par, ovr, dr} |

## Verification
A wrong errored-character count hides until a read lands while the FIFO drains. Bit 7 then stays set, or drops early, on the edge after that read. The bench therefore mixes many tagged pushes, pops and reads so that the count passes through zero often. A head flag latched from the wrong tag, or a lost set-versus-clear priority, shows in bits 1 to 4 one edge after the event. Every bit is compared against a behavioural queue model on every clock, so any divergence is reported within one cycle.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int unsigned LSR_W   = 8;
  localparam int unsigned TAG_W   = 3;
  localparam int unsigned B_DR    = 0;
  localparam int unsigned B_OVR   = 1;
  localparam int unsigned B_PAR   = 2;
  localparam int unsigned B_FRM   = 3;
  localparam int unsigned B_BRK   = 4;
  localparam int unsigned B_THRE  = 5;
  localparam int unsigned B_TEMT  = 6;
  localparam int unsigned B_FERR  = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_tag_t;
endpackage

// File: rtl/lsr_err_count.sv
module lsr_err_count #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero_next
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc ^ dec;
    if (inc && !dec && cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0)       cnt_d = cnt_q - 1'b1;
  end

  assign zero_next = (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_cnt_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt_q != CNT_W'(DEPTH)) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lsr_rx_flags.sv
module lsr_rx_flags
  import uart_lsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       ovr_evt,
  input  logic       head_load,
  input  err_tag_t   head_tag,
  input  logic       rd,
  input  logic       cnt_zero_next,
  output logic       ovr,
  output err_tag_t   err,
  output logic       fifo_err
);
  logic     ovr_q, ovr_d;
  err_tag_t err_q, err_d;
  logic     ferr_q, ferr_d;
  logic     head_bad;

  assign head_bad = head_load && (head_tag != '0);

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_evt)  ovr_d = 1'b1;
    else if (rd)  ovr_d = 1'b0;

    err_d = err_q;
    if (head_load) err_d = head_tag;
    else if (rd)   err_d = '0;

    ferr_d = ferr_q;
    if (!fifo_en)                  ferr_d = 1'b0;
    else if (head_bad)             ferr_d = 1'b1;
    else if (rd && cnt_zero_next)  ferr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      err_q  <= '0;
      ferr_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_d;
      err_q  <= err_d;
      ferr_q <= ferr_d;
    end
  end

  assign ovr      = ovr_q;
  assign err      = err_q;
  assign fifo_err = ferr_q;

  p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr);
  p_head_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    head_load |=> err == $past(head_tag));
  p_rd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !head_load) |=> err == '0);
  p_ferr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && head_bad) |=> fifo_err);
  p_ferr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !fifo_err);
endmodule

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic hold_empty,
  input  logic shift_empty,
  output logic thre,
  output logic temt
);
  logic thre_q, thre_d;

  always_comb begin
    thre_d = thre_q;
    if (wr)              thre_d = 1'b0;
    else if (hold_empty) thre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thre_q <= 1'b1;
    else        thre_q <= thre_d;
  end

  assign thre = thre_q;
  assign temt = thre_q & shift_empty;

  p_thre_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !thre);
  p_thre_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && !wr) |=> thre);
  p_temt_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !temt);
endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_push,
  input  logic [2:0] rx_push_tag,
  input  logic       rx_full,
  input  logic       rx_pop,
  input  logic [2:0] rx_pop_tag,
  input  logic       rx_head_load,
  input  logic [2:0] rx_head_tag,
  input  logic       rx_nonempty,
  input  logic       thr_wr,
  input  logic       thr_empty,
  input  logic       tsr_empty,
  input  logic       lsr_rd,
  output logic [7:0] lsr
);
  logic     cnt_inc, cnt_dec, cnt_zero_next;
  logic     ovr, fifo_err, thre, temt;
  err_tag_t err;

  assign cnt_inc = rx_push && !rx_full && (rx_push_tag != '0);
  assign cnt_dec = rx_pop && (rx_pop_tag != '0);

  lsr_err_count #(.DEPTH(DEPTH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (cnt_inc),
    .dec       (cnt_dec),
    .zero_next (cnt_zero_next)
  );

  lsr_rx_flags u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .ovr_evt       (rx_push && rx_full),
    .head_load     (rx_head_load),
    .head_tag      (err_tag_t'(rx_head_tag)),
    .rd            (lsr_rd),
    .cnt_zero_next (cnt_zero_next),
    .ovr           (ovr),
    .err           (err),
    .fifo_err      (fifo_err)
  );

  lsr_tx_flags u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (thr_wr),
    .hold_empty  (thr_empty),
    .shift_empty (tsr_empty),
    .thre        (thre),
    .temt        (temt)
  );

  always_comb begin
    lsr         = '0;
    lsr[B_DR]   = rx_nonempty;
    lsr[B_OVR]  = ovr;
    lsr[B_PAR]  = err.par;
    lsr[B_FRM]  = err.frm;
    lsr[B_BRK]  = err.brk;
    lsr[B_THRE] = thre;
    lsr[B_TEMT] = temt;
    lsr[B_FERR] = fifo_err;
  end

  p_dr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[B_DR] == rx_nonempty);
endmodule

// File: tb/uart_lsr_tb.sv
module uart_lsr_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b1, rx_push = 1'b0, rx_full = 1'b0, rx_pop = 1'b0;
  logic [2:0] rx_push_tag = '0, rx_pop_tag = '0, rx_head_tag = '0;
  logic rx_head_load = 1'b0, rx_nonempty = 1'b0;
  logic thr_wr = 1'b0, thr_empty = 1'b1, tsr_empty = 1'b1, lsr_rd = 1'b0;
  logic [7:0] lsr;

  always #(CLK_P/2) clk = ~clk;

  uart_lsr #(.DEPTH(DEPTH)) u_dut (.*);

  int checks = 0, fails = 0;
  int q[$];
  bit m_ovr, m_par, m_frm, m_brk, m_thre, m_ferr;
  bit hold_full;
  int tsr_left;

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(lsr[0], rx_nonempty,          "R1 data ready");
    chk(lsr[1], m_ovr,                "R2 overrun");
    chk(lsr[2], m_par,                "R3 parity");
    chk(lsr[3], m_frm,                "R3 framing");
    chk(lsr[4], m_brk,                "R4 break");
    chk(lsr[5], m_thre,               "R5 holding empty");
    chk(lsr[6], m_thre && tsr_empty,  "R6 transmitter empty");
    chk(lsr[7], m_ferr,               "R8 fifo error");
  endtask

  function automatic int errored(input int qq[$]);
    int n = 0;
    foreach (qq[i]) if (qq[i] != 0) n++;
    return n;
  endfunction

  task automatic step(input int p_push, input int p_pop, input int p_err,
                      input int p_rd, input int p_wr, input bit en);
    int nq[$];
    bit push, pop, rd, wr, full, hl;
    int tag, htag, ptag;
    @(negedge clk);
    compare();
    full = (q.size() == DEPTH);
    push = ($urandom % 100) < p_push;
    pop  = (q.size() > 0) && (($urandom % 100) < p_pop);
    tag  = (($urandom % 100) < p_err) ? (1 + $urandom % 7) : 0;
    rd   = ($urandom % 100) < p_rd;
    wr   = ($urandom % 100) < p_wr;
    ptag = (q.size() > 0) ? q[0] : 0;
    nq = q;
    if (pop) void'(nq.pop_front());
    if (push && !full) nq.push_back(tag);
    hl   = (nq.size() > 0) && (pop || q.size() == 0) && (push || pop);
    htag = hl ? nq[0] : 0;
    fifo_en = en; rx_push = push; rx_push_tag = 3'(tag); rx_full = full;
    rx_pop = pop; rx_pop_tag = 3'(ptag); rx_head_load = hl; rx_head_tag = 3'(htag);
    rx_nonempty = (q.size() > 0); lsr_rd = rd; thr_wr = wr;
    thr_empty = !hold_full; tsr_empty = (tsr_left == 0);
    // reference model state after the coming edge
    if (push && full) m_ovr = 1; else if (rd) m_ovr = 0;                 // R2
    if (hl) begin m_par = htag[0]; m_frm = htag[1]; m_brk = htag[2]; end  // R3
    else if (rd) begin m_par = 0; m_frm = 0; m_brk = 0; end               // R4
    if (wr) m_thre = 0; else if (thr_empty) m_thre = 1;                   // R5
    if (!en) m_ferr = 0;                                                  // R9
    else if (hl && htag != 0) m_ferr = 1;                                 // R8
    else if (rd && errored(nq) == 0) m_ferr = 0;                          // R7
    q = nq;
    if (tsr_left > 0) tsr_left--;
    else if (hold_full) begin hold_full = 0; tsr_left = 1 + $urandom % 6; end
    if (wr) hold_full = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_thre = 1; hold_full = 0; tsr_left = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (lsr !== 8'h60) begin
      fails++;
      $display("FAIL R10 reset actual=%h expected=60", lsr);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) step(40, 35, 30, 10, 10, 1'b1);   // mixed traffic
    for (int i = 0; i < 2000; i++) step(70, 10, 50, 15, 5, 1'b1);    // fill and overrun
    for (int i = 0; i < 2000; i++) step(10, 60, 40, 40, 30, 1'b1);   // drain with frequent reads
    for (int i = 0; i < 1000; i++) step(40, 40, 50, 20, 10, 1'b0);   // fifo mode off
    for (int i = 0; i < 2000; i++) step(30, 30, 20, 60, 20, 1'b1);   // read-heavy
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule